// File: doc/BRIEF.md
# DC-Balanced Word Codec for One Data Lane

This block holds both ends of one lane's line coding. On the sending side, each 7-bit parallel word is checked against the sign of the lane's running digital sum. In that sum a transmitted 1 adds one and a transmitted 0 subtracts one. The word is then either sent as it is or inverted, and a two-bit complementary marker is placed in front of it. The result is a 9-bit symbol, presented in parallel one cycle after the word is accepted.

On the receiving side, a 9-bit symbol is taken in, its marker is read, and the original word is restored. A marker whose two bits are equal is reported for one cycle as an error.

Because every word is odd in length, a word's disparity is never zero. Steering each word against the running sign therefore keeps the bit-by-bit sum of the sent stream within ten of zero in both directions. Serial shifting, line drivers and clock recovery are outside this block. The two sides have independent ports so that they can sit at opposite ends of a link.

Top module: `dcb_codec`

## Requirements
- R1: An encoded symbol carries its marker in bits [8:7] and the sent data in bits [6:0]. Marker 2'b10 means the data is sent unchanged and 2'b01 means it is sent bit-inverted.
- R2: Every valid encoded symbol has a marker whose two bits differ.
- R3: When the running sum is above zero, the sent data bits hold more zeros than ones. When the sum is zero or below, they hold more ones than zeros.
- R4: Reset sets the running sum to zero. Each accepted word changes the sum by the count of ones minus the count of zeros in its 7 sent data bits; the marker adds nothing.
- R5: Walking the valid encoded symbols bit by bit, starting at bit 8 and ending at bit 0, the cumulative sum never leaves the range -10 to +10.
- R6: An accepted word appears as a symbol, with enc_out_valid high, exactly one cycle later. A cycle without enc_in_valid gives enc_out_valid low on the next cycle and leaves the running sum unchanged.
- R7: A valid symbol with marker 2'b10 is decoded to its bits [6:0], and one with marker 2'b01 is decoded to the inverse of those bits. dec_out_valid is high one cycle after dec_in_valid.
- R8: A valid symbol with marker 2'b00 or 2'b11 raises dec_flag_error for exactly the next cycle, together with dec_out_valid, and its bits [6:0] are output without inversion. An invalid input never raises the error.
- R9: While reset is held and until its synchronised release, enc_out_valid, dec_out_valid and dec_flag_error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_in_valid | input | 1 | A word is offered to the encoder this cycle |
| enc_in_data | input | 7 | Word to encode |
| enc_out_valid | output | 1 | enc_out_sym holds a new symbol |
| enc_out_sym | output | 9 | Encoded symbol, marker in the top two bits |
| dec_in_valid | input | 1 | A symbol is offered to the decoder this cycle |
| dec_in_sym | input | 9 | Symbol to decode |
| dec_out_valid | output | 1 | dec_out_data holds a decoded word |
| dec_out_data | output | 7 | Restored word |
| dec_flag_error | output | 1 | The decoded symbol had a non-complementary marker |

## Verification
The in-design assertions take the word width to be odd, so that no word is ever balanced and the sign rule always moves the sum toward zero. They also take inputs to be sampled only on a valid cycle; symbols with invalid markers are handled as ordinary traffic.

The stimulus keeps to the default width. It changes inputs only between rising edges and puts gaps into the traffic, so both the hold case and the update case of the sum are reached. It feeds the decoder both from the encoder's own output and with crafted symbols carrying each illegal marker. Word sequences are chosen to drive the stream to both the upper and the lower peak of the bit-level sum.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  typedef enum logic [1:0] {
    MARK_BAD_LO = 2'b00,
    MARK_INV    = 2'b01,
    MARK_PLAIN  = 2'b10,
    MARK_BAD_HI = 2'b11
  } mark_e;

  localparam int MARK_W = 2;

  // Width of a signed quantity that holds a word disparity or the running sum.
  function automatic int sum_width(input int data_w);
    return $clog2(data_w) + 3;
  endfunction

endpackage

// File: rtl/dcb_rst_sync.sv
module dcb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/dcb_weight.sv
module dcb_weight #(
  parameter int DATA_W = 7,
  parameter int OUT_W  = 6
) (
  input  logic [DATA_W-1:0]       word,
  output logic signed [OUT_W-1:0] disp
);

  localparam int CNT_W = OUT_W - 1;

  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) begin
      ones = ones + CNT_W'(word[i]);
    end
  end

  // disparity = ones - zeros = 2*ones - DATA_W
  assign disp = $signed({ones, 1'b0}) - $signed(OUT_W'(DATA_W));

endmodule

// File: rtl/dcb_encoder.sv
module dcb_encoder
  import dcb_pkg::*;
#(
  parameter int DATA_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_data,
  output logic                     out_valid,
  output logic [DATA_W+MARK_W-1:0] out_sym
);

  localparam int SUM_W = sum_width(DATA_W);
  localparam int SYM_W = DATA_W + MARK_W;
  localparam logic signed [SUM_W-1:0] SUM_HI = SUM_W'(DATA_W);
  localparam logic signed [SUM_W-1:0] SUM_LO = -SUM_HI + SUM_W'(1);

  logic signed [SUM_W-1:0] sum_q, sum_d;
  logic signed [SUM_W-1:0] raw_disp, sent_disp;
  logic                    sum_pos, raw_neg, flip;
  logic [SYM_W-1:0]        sym_q, sym_d;
  logic                    valid_q;

  dcb_weight #(.DATA_W(DATA_W), .OUT_W(SUM_W)) u_weight (
    .word (in_data),
    .disp (raw_disp)
  );

  // next-state logic
  always_comb begin
    sum_pos   = !sum_q[SUM_W-1] && (sum_q != '0);
    raw_neg   = raw_disp[SUM_W-1];
    // Positive sum: send the zero-heavy polarity; otherwise the one-heavy one.
    flip      = sum_pos ? !raw_neg : raw_neg;
    sent_disp = flip ? -raw_disp : raw_disp;
    sum_d     = sum_q + sent_disp;
    sym_d     = {(flip ? MARK_INV : MARK_PLAIN), (flip ? ~in_data : in_data)};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      sym_q <= '0;
    end else if (in_valid) begin
      sum_q <= sum_d;
      sym_q <= sym_d;
    end
  end

  assign out_valid = valid_q;
  assign out_sym   = sym_q;

  // R2: marker halves always differ on a valid symbol
  a_r2_mark_compl: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sym[SYM_W-1] != out_sym[SYM_W-2]));

  // R3: positive sum gives a zero-heavy data field
  a_r3_pos_zero_heavy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sum_pos) |=> ($countones(out_sym[DATA_W-1:0]) <= DATA_W/2));

  // R3: non-positive sum gives a one-heavy data field
  a_r3_nonpos_one_heavy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sum_pos) |=> ($countones(out_sym[DATA_W-1:0]) > DATA_W/2));

  // R5: word-boundary sum stays inside the range that bounds the bit-level peak
  a_r5_sum_range: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_q <= SUM_HI) && (sum_q >= SUM_LO));

  // R6: idle cycle gives no symbol and holds the sum
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(sum_q)));

endmodule

// File: rtl/dcb_decoder.sv
module dcb_decoder
  import dcb_pkg::*;
#(
  parameter int DATA_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DATA_W+MARK_W-1:0] in_sym,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_data,
  output logic                     out_err
);

  localparam int SYM_W = DATA_W + MARK_W;

  mark_e             mark;
  logic              mark_ok, undo;
  logic [DATA_W-1:0] data_d, data_q;
  logic              err_d, err_q, valid_q;

  // next-state logic
  always_comb begin
    mark    = mark_e'(in_sym[SYM_W-1 -: MARK_W]);
    mark_ok = (mark == MARK_PLAIN) || (mark == MARK_INV);
    undo    = (mark == MARK_INV);
    data_d  = undo ? ~in_sym[DATA_W-1:0] : in_sym[DATA_W-1:0];
    err_d   = in_valid && !mark_ok;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= in_valid;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (in_valid) begin
      data_q <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_err   = err_q;

  // R7: inverted marker restores the complement
  a_r7_undo_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sym[SYM_W-1 -: MARK_W] == 2'b01) |=>
      (out_valid && !out_err && out_data == ~$past(in_sym[DATA_W-1:0])));

  // R8: illegal marker flags an error and passes data as is
  a_r8_bad_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_sym[SYM_W-1] == in_sym[SYM_W-2])) |=>
      (out_valid && out_err && out_data == $past(in_sym[DATA_W-1:0])));

  // R8: no error without a valid input
  a_r8_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_err);

endmodule

// File: rtl/dcb_codec.sv
module dcb_codec #(
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_in_valid,
  input  logic [DATA_W-1:0] enc_in_data,
  output logic              enc_out_valid,
  output logic [DATA_W+1:0] enc_out_sym,
  input  logic              dec_in_valid,
  input  logic [DATA_W+1:0] dec_in_sym,
  output logic              dec_out_valid,
  output logic [DATA_W-1:0] dec_out_data,
  output logic              dec_flag_error
);

  logic rst_n_sync;

  dcb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dcb_encoder #(.DATA_W(DATA_W)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .in_valid  (enc_in_valid),
    .in_data   (enc_in_data),
    .out_valid (enc_out_valid),
    .out_sym   (enc_out_sym)
  );

  dcb_decoder #(.DATA_W(DATA_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .in_valid  (dec_in_valid),
    .in_sym    (dec_in_sym),
    .out_valid (dec_out_valid),
    .out_data  (dec_out_data),
    .out_err   (dec_flag_error)
  );

  // R9: held reset keeps every valid and error output low
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n_sync |-> (!enc_out_valid && !dec_out_valid && !dec_flag_error));

endmodule

// File: tb/tb_dcb_codec.sv
module tb_dcb_codec;

  localparam int CLK_PERIOD = 10;
  localparam int W = 7;

  logic         clk;
  logic         rst_n;
  logic         enc_in_valid;
  logic [W-1:0] enc_in_data;
  logic         enc_out_valid;
  logic [W+1:0] enc_out_sym;
  logic         dec_in_valid;
  logic [W+1:0] dec_in_sym;
  logic         dec_out_valid;
  logic [W-1:0] dec_out_data;
  logic         dec_flag_error;

  dcb_codec #(.DATA_W(W)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .enc_in_valid   (enc_in_valid),
    .enc_in_data    (enc_in_data),
    .enc_out_valid  (enc_out_valid),
    .enc_out_sym    (enc_out_sym),
    .dec_in_valid   (dec_in_valid),
    .dec_in_sym     (dec_in_sym),
    .dec_out_valid  (dec_out_valid),
    .dec_out_data   (dec_out_data),
    .dec_flag_error (dec_flag_error)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int           model_sum;
  int           line_sum;
  int           line_max;
  int           line_min;
  bit           exp_ev;
  logic [W+1:0] exp_sym;
  bit           exp_dv;
  logic [W-1:0] exp_dd;
  bit           exp_de;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_idle_expect();
    exp_ev = 0; exp_sym = '0; exp_dv = 0; exp_dd = '0; exp_de = 0;
    model_sum = 0; line_sum = 0;
  endtask

  // Compare all outputs against the model, then apply new inputs.
  task automatic step(input bit ev, input logic [W-1:0] ed,
                      input bit loop, input bit dv, input logic [W+1:0] ds);
    logic [W+1:0] seen_sym;
    bit           seen_v;
    int           ones;
    bit           inv;
    logic [W-1:0] sent;
    @(negedge clk);
    seen_v   = enc_out_valid;
    seen_sym = enc_out_sym;
    check(enc_out_valid == exp_ev, "R6", "enc_out_valid", 32'(enc_out_valid), 32'(exp_ev));
    if (exp_ev) begin
      check(enc_out_sym == exp_sym, "R1 R3 R4", "enc_out_sym", 32'(enc_out_sym), 32'(exp_sym));
      check(enc_out_sym[8] != enc_out_sym[7], "R2", "marker", 32'(enc_out_sym[8:7]), 32'h2);
      for (int b = W+1; b >= 0; b--) begin
        line_sum += enc_out_sym[b] ? 1 : -1;
        if (line_sum > line_max) line_max = line_sum;
        if (line_sum < line_min) line_min = line_sum;
      end
      check(line_max <= 10 && line_min >= -10, "R5", "bit-level sum peak",
            32'(line_max), 32'd10);
    end
    check(dec_out_valid == exp_dv, "R7", "dec_out_valid", 32'(dec_out_valid), 32'(exp_dv));
    check(dec_flag_error == exp_de, "R8", "dec_flag_error", 32'(dec_flag_error), 32'(exp_de));
    if (exp_dv)
      check(dec_out_data == exp_dd, "R7 R8", "dec_out_data", 32'(dec_out_data), 32'(exp_dd));

    // drive encoder and predict its next output
    enc_in_valid = ev;
    enc_in_data  = ed;
    exp_ev = ev;
    if (ev) begin
      ones = $countones(ed);
      if (model_sum > 0) inv = (2*ones > W);
      else               inv = (2*ones < W);
      sent = inv ? ~ed : ed;
      model_sum += 2*$countones(sent) - W;
      exp_sym = {(inv ? 2'b01 : 2'b10), sent};
    end

    // drive decoder and predict its next output
    if (loop) begin
      dec_in_valid = seen_v;
      dec_in_sym   = seen_sym;
    end else begin
      dec_in_valid = dv;
      dec_in_sym   = ds;
    end
    exp_dv = dec_in_valid;
    exp_de = 0;
    if (dec_in_valid) begin
      case (dec_in_sym[8:7])
        2'b10:   exp_dd = dec_in_sym[W-1:0];
        2'b01:   exp_dd = ~dec_in_sym[W-1:0];
        default: begin exp_dd = dec_in_sym[W-1:0]; exp_de = 1; end
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    enc_in_valid = 0; enc_in_data = '0; dec_in_valid = 0; dec_in_sym = '0;
    repeat (2) begin
      @(negedge clk);
      check(!enc_out_valid && !dec_out_valid && !dec_flag_error, "R9",
            "outputs in reset", 32'({enc_out_valid, dec_out_valid, dec_flag_error}), 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(!enc_out_valid && !dec_out_valid && !dec_flag_error, "R9",
          "outputs during release", 32'({enc_out_valid, dec_out_valid, dec_flag_error}), 32'd0);
    repeat (2) @(negedge clk);
    set_idle_expect();
  endtask

  initial begin
    rst_n = 1'b1;
    enc_in_valid = 0; enc_in_data = '0; dec_in_valid = 0; dec_in_sym = '0;
    line_max = 0; line_min = 0;
    set_idle_expect();
    @(negedge clk);
    rst_n = 1'b0;
    do_reset();

    // R4: from zero, the one-heavy polarity; then flips as the sum turns positive
    step(1, 7'h7F, 1, 0, '0);   // plain 7F, sum 7
    step(1, 7'h7F, 1, 0, '0);   // inverted to 00, sum 0
    step(1, 7'h00, 1, 0, '0);   // inverted to 7F, sum 7
    // R6: gaps hold the sum
    step(0, 7'h55, 1, 0, '0);
    step(0, 7'h2A, 1, 0, '0);
    step(1, 7'h55, 1, 0, '0);   // sum 7 > 0, 4 ones -> inverted
    step(1, 7'h2A, 1, 0, '0);
    step(0, '0, 1, 0, '0);
    step(0, '0, 1, 0, '0);

    // R5: upper peak, sum 7 then a zero-heavy word with ones leading
    do_reset();
    step(1, 7'h7F, 1, 0, '0);
    step(1, 7'b1110000, 1, 0, '0);
    step(0, '0, 1, 0, '0);
    step(0, '0, 1, 0, '0);
    check(line_max == 10, "R5", "upper peak reached", 32'(line_max), 32'd10);

    // R5: lower peak, sum -6 then a one-heavy word with zeros leading
    do_reset();
    step(1, 7'b0001111, 1, 0, '0);   // sum 1
    step(1, 7'h7F, 1, 0, '0);        // inverted to 00, sum -6
    step(1, 7'b0001111, 1, 0, '0);   // bit-level minimum -9
    step(0, '0, 1, 0, '0);
    step(0, '0, 1, 0, '0);
    check(line_min == -9, "R5", "lower peak reached", 32'(line_min), -32'sd9);

    // mixed traffic with gaps, decoder in loopback (R3 R4 R6 R7)
    for (int n = 0; n < 400; n++) begin
      step(($urandom % 4) != 0, 7'($urandom), 1, 0, '0);
    end
    step(0, '0, 1, 0, '0);
    step(0, '0, 1, 0, '0);

    // R8: illegal markers, then legal ones, then an invalid input with a bad marker
    step(0, '0, 0, 1, 9'b00_1010101);
    step(0, '0, 0, 1, 9'b11_0110011);
    step(0, '0, 0, 1, 9'b10_1100110);
    step(0, '0, 0, 1, 9'b01_1100110);
    step(0, '0, 0, 0, 9'b11_1111111);
    step(0, '0, 0, 1, 9'b11_0000001);
    step(0, '0, 0, 0, 9'b00_0000000);
    step(0, '0, 0, 0, '0);

    // R4: reset mid-stream returns the sum to zero
    step(1, 7'h7F, 0, 0, '0);
    do_reset();
    step(1, 7'h00, 0, 0, '0);   // sum 0 -> one-heavy: 01_1111111
    step(0, '0, 0, 0, '0);
    check(exp_sym == 9'b01_1111111, "R4", "model after reset", 32'(exp_sym), 32'h0FF);
    step(0, '0, 0, 0, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule